// File: doc/BRIEF.md
# VLIW Bundle Resource Hazard Checker

This block sits at the issue stage of a five-slot VLIW core. In each cycle it looks at the bundle on offer and decides whether that bundle may issue. Each slot gives a valid bit and a functional-unit type code. The checker makes sure of three things: each operation sits in a slot that has the required unit attached, the non-pipelined iterative divide/square-root unit has finished recovering, and the register-file write ports are not oversubscribed in the cycle when each result comes back. A result comes back a fixed, per-unit latency after issue.

Write-port pressure is tracked by a reservation window. The window is a shift register with one entry per future cycle, up to the longest latency. Each entry counts the writes already booked for that cycle. An accepted bundle adds its operations at their latencies, and a rejected bundle adds nothing. The iterative unit has a two-state tracker. `ITER_IDLE` moves to `ITER_BUSY` when an iterative operation is accepted, and a countdown is loaded at that point. `ITER_BUSY` stays put while the count is above one. It returns to `ITER_IDLE` on the cycle the count reaches one, so the unit can take a new operation on the next cycle.

The accept flag and the per-slot error codes are combinational in the current bundle and the stored state. State changes only on the clock edge that follows.

Top module: `vliw_issue_guard`

## Requirements
- R1: Unit codes are 4 bits. Each code is attached to these slots: 0 immediate (all slots), 1 integer (all slots), 2 packed-SIMD ALU (slots 0, 2, 4), 3 packed-SIMD multiply (slots 1, 2), 4 load/store (slots 3, 4), 5 cache control (slot 4), 6 shifter (slots 0, 1), 7 branch (slots 1, 2, 3), 8 FP add (slots 0, 3), 9 multiplier (slots 1, 2), 10 FP compare (slot 2), 11 iterative FP divide/sqrt (slot 1). Codes 12 to 15 are attached to no slot. A valid slot whose code is not attached there reports code 1, and the bundle is rejected.
- R2: Every operation writes one result, exactly its latency after issue. Codes 0, 1, 6 and 10 take 1 cycle, code 2 takes 2 cycles, codes 3, 4, 5, 7, 8 and 9 take 3 cycles, and code 11 takes ITER_LAT cycles (default 17).
- R3: Each slot has a 2-bit error field at slot_err[2i+1:2i]: 0 means none, 1 means unit not attached, 2 means unit not recovered, 3 means write-port overflow. A slot shows at most one cause, and the precedence is 1 over 2 over 3. An invalid slot shows 0.
- R4: If an iterative operation is accepted in cycle c, every iterative operation offered in cycles c+1 through c+ITER_RECOVERY-1 reports code 2. One offered in cycle c+ITER_RECOVERY (default 16) is accepted.
- R5: No future cycle may hold more than WB_PORTS (default 5) writes. A valid, attached, recovered slot reports code 3 when the writes already booked for its landing cycle, plus the writes of same-latency slots with an index up to and including its own, exceed WB_PORTS.
- R6: bundle_ok is high exactly when every slot's code is 0. A bundle with no valid slot is accepted.
- R7: A rejected bundle books no writes and does not start the iterative countdown. The window still advances one cycle.
- R8: After reset the window holds no bookings and the iterative unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | NUM_SLOTS | Per-slot operation present |
| slot_unit | input | NUM_SLOTS*UNIT_W | Unit type code, slot i at bits [UNIT_W*i +: UNIT_W] |
| bundle_ok | output | 1 | Bundle may issue this cycle |
| slot_err | output | NUM_SLOTS*2 | Per-slot error code |

## Verification
The hardest case to reach is a write-port overflow made by bookings from different cycles. An iterative operation booked 17 cycles ahead has to collide with 3-cycle and 2-cycle operations issued much later. The stimulus issues an iterative operation, idles through empty bundles, fills the matching landing cycle with four 3-cycle operations, and then offers one 2-cycle operation that lands in the same cycle. A second sequence shows that a rejected bundle books nothing. A probe after the rejection overflows on its second slot but not on its first.

// File: rtl/vig_pkg.sv
package vig_pkg;

    localparam int UNIT_W = 4;

    typedef enum logic [UNIT_W-1:0] {
        UT_IMM     = 4'd0,
        UT_INT     = 4'd1,
        UT_SIMD    = 4'd2,
        UT_SIMDMUL = 4'd3,
        UT_LDST    = 4'd4,
        UT_CACHE   = 4'd5,
        UT_SHIFT   = 4'd6,
        UT_BRANCH  = 4'd7,
        UT_FADD    = 4'd8,
        UT_MUL     = 4'd9,
        UT_FCMP    = 4'd10,
        UT_FITER   = 4'd11
    } unit_t;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_NO_UNIT = 2'd1,
        ERR_BUSY    = 2'd2,
        ERR_WB_FULL = 2'd3
    } err_t;

    // Cycles from issue to register-file write for a unit type.
    function automatic int unsigned unit_latency(logic [UNIT_W-1:0] code, int unsigned iter_lat);
        unique case (code)
            UT_IMM, UT_INT, UT_SHIFT, UT_FCMP:                      return 1;
            UT_SIMD:                                                return 2;
            UT_SIMDMUL, UT_LDST, UT_CACHE, UT_BRANCH, UT_FADD, UT_MUL: return 3;
            UT_FITER:                                               return iter_lat;
            default:                                                return 1;
        endcase
    endfunction

    // Slot-to-unit attachment; bit n of the mask is slot n.
    function automatic logic slot_has_unit(int unsigned slot, logic [UNIT_W-1:0] code);
        logic [4:0] mask;
        unique case (code)
            UT_IMM, UT_INT: mask = 5'b11111;
            UT_SIMD:        mask = 5'b10101;
            UT_SIMDMUL:     mask = 5'b00110;
            UT_LDST:        mask = 5'b11000;
            UT_CACHE:       mask = 5'b10000;
            UT_SHIFT:       mask = 5'b00011;
            UT_BRANCH:      mask = 5'b01110;
            UT_FADD:        mask = 5'b01001;
            UT_MUL:         mask = 5'b00110;
            UT_FCMP:        mask = 5'b00100;
            UT_FITER:       mask = 5'b00010;
            default:        mask = 5'b00000;
        endcase
        if (slot < 5) return mask[slot];
        return 1'b0;
    endfunction

endpackage

// File: rtl/vig_slot_decode.sv
module vig_slot_decode
    import vig_pkg::*;
#(
    parameter int SLOT_IDX = 0,
    parameter int ITER_LAT = 17,
    parameter int LAT_W    = 5
) (
    input  logic [UNIT_W-1:0] unit_code,
    output logic              attached,
    output logic              is_iter,
    output logic [LAT_W-1:0]  lat
);

    always_comb begin
        attached = slot_has_unit(SLOT_IDX, unit_code);
        is_iter  = (unit_code == UT_FITER);
        lat      = LAT_W'(unit_latency(unit_code, ITER_LAT));
    end

endmodule

// File: rtl/vig_iter_fsm.sv
module vig_iter_fsm #(
    parameter int RECOVERY = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    output logic busy
);

    localparam int  CW       = $clog2(RECOVERY + 1);
    localparam bit  HAS_WAIT = (RECOVERY > 1);

    typedef enum logic {ITER_IDLE, ITER_BUSY} iter_state_t;

    iter_state_t    state, state_n;
    logic [CW-1:0]  cnt, cnt_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ITER_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            ITER_IDLE: begin
                if (issue && HAS_WAIT) begin
                    state_n = ITER_BUSY;
                    cnt_n   = CW'(RECOVERY - 1);
                end
            end
            ITER_BUSY: begin
                cnt_n = cnt - 1'b1;
                if (cnt == CW'(1)) state_n = ITER_IDLE;
            end
            default: state_n = ITER_IDLE;
        endcase
    end

    always_comb busy = (state == ITER_BUSY);

    AST_ITER_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !issue); // R4
    AST_ITER_BUSY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_WAIT && issue) |=> busy); // R4

endmodule

// File: rtl/vig_wb_window.sv
module vig_wb_window #(
    parameter int DEPTH     = 17,
    parameter int NUM_SLOTS = 5,
    parameter int WB_PORTS  = 5,
    parameter int LAT_W     = 5,
    parameter int CNT_W     = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit,
    input  logic [NUM_SLOTS-1:0]       add_en,
    input  logic [NUM_SLOTS*LAT_W-1:0] add_lat,
    output logic [DEPTH*CNT_W-1:0]     occ_flat
);

    localparam int SUM_W = $clog2(WB_PORTS + NUM_SLOTS + 1);

    // resv[d] counts writes landing d+1 cycles after the current one.
    logic [CNT_W-1:0] resv [DEPTH];

    genvar d;
    generate
        for (d = 0; d < DEPTH; d++) begin : g_entry
            logic [SUM_W-1:0] add_cnt;
            logic [SUM_W-1:0] nxt;

            always_comb begin
                add_cnt = '0;
                for (int s = 0; s < NUM_SLOTS; s++) begin
                    if (commit && add_en[s] && add_lat[s*LAT_W +: LAT_W] == LAT_W'(d + 2))
                        add_cnt = add_cnt + 1'b1;
                end
            end

            if (d + 1 < DEPTH) begin : g_shift
                always_comb nxt = SUM_W'(resv[d+1]) + add_cnt;
                AST_WB_HOLD_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
                    !commit |=> resv[d] == $past(resv[d+1])); // R7
            end else begin : g_top
                always_comb nxt = add_cnt;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) resv[d] <= '0;
                else        resv[d] <= CNT_W'(nxt);
            end

            assign occ_flat[d*CNT_W +: CNT_W] = resv[d];

            AST_WB_WITHIN_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
                int'(resv[d]) <= WB_PORTS); // R5
        end
    endgenerate

endmodule

// File: rtl/vliw_issue_guard.sv
module vliw_issue_guard
    import vig_pkg::*;
#(
    parameter int NUM_SLOTS     = 5,
    parameter int WB_PORTS      = 5,
    parameter int ITER_LAT      = 17,
    parameter int ITER_RECOVERY = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SLOTS-1:0]        slot_valid,
    input  logic [NUM_SLOTS*UNIT_W-1:0] slot_unit,
    output logic                        bundle_ok,
    output logic [NUM_SLOTS*2-1:0]      slot_err
);

    localparam int MAX_LAT = ITER_LAT;
    localparam int LAT_W   = $clog2(MAX_LAT + 1);
    localparam int CNT_W   = $clog2(WB_PORTS + 1);
    localparam int SUM_W   = $clog2(WB_PORTS + NUM_SLOTS + 1);

    logic [NUM_SLOTS-1:0]       attached;
    logic [NUM_SLOTS-1:0]       is_iter;
    logic [LAT_W-1:0]           lat [NUM_SLOTS];
    logic [NUM_SLOTS*LAT_W-1:0] lat_flat;
    logic [NUM_SLOTS-1:0]       elig;
    err_t                       errs [NUM_SLOTS];
    logic [MAX_LAT*CNT_W-1:0]   occ_flat;
    logic [CNT_W-1:0]           occ [MAX_LAT];
    logic                       iter_busy;
    logic                       iter_issue;

    genvar i;
    generate
        for (i = 0; i < NUM_SLOTS; i++) begin : g_slot
            vig_slot_decode #(
                .SLOT_IDX (i),
                .ITER_LAT (ITER_LAT),
                .LAT_W    (LAT_W)
            ) u_dec (
                .unit_code (slot_unit[i*UNIT_W +: UNIT_W]),
                .attached  (attached[i]),
                .is_iter   (is_iter[i]),
                .lat       (lat[i])
            );
            assign lat_flat[i*LAT_W +: LAT_W] = lat[i];
            assign slot_err[i*2 +: 2]         = errs[i];

            AST_SLOT_WITHOUT_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
                (slot_valid[i] && !attached[i]) |-> !bundle_ok); // R1
            AST_BUSY_REJECTS_ITER: assert property (@(posedge clk) disable iff (!rst_n)
                (iter_busy && slot_valid[i] && is_iter[i]) |-> (!bundle_ok && slot_err[i*2 +: 2] != 2'd0)); // R4
        end
        for (i = 0; i < MAX_LAT; i++) begin : g_occ
            assign occ[i] = occ_flat[i*CNT_W +: CNT_W];
        end
    endgenerate

    // Per-slot classification: attachment, then recovery, then write-port load.
    always_comb begin
        logic             claim;
        logic [SUM_W-1:0] tally;
        claim = iter_busy;
        tally = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            errs[s] = ERR_NONE;
            elig[s] = 1'b0;
            if (slot_valid[s]) begin
                if (!attached[s]) begin
                    errs[s] = ERR_NO_UNIT;
                end else if (is_iter[s] && claim) begin
                    errs[s] = ERR_BUSY;
                end else begin
                    elig[s] = 1'b1;
                    if (is_iter[s]) claim = 1'b1;
                end
            end
        end
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (elig[s]) begin
                tally = SUM_W'(occ[lat[s] - 1'b1]);
                for (int k = 0; k <= s; k++) begin
                    if (elig[k] && lat[k] == lat[s]) tally = tally + 1'b1;
                end
                if (int'(tally) > WB_PORTS) errs[s] = ERR_WB_FULL;
            end
        end
    end

    always_comb begin
        bundle_ok = 1'b1;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (errs[s] != ERR_NONE) bundle_ok = 1'b0;
        end
        iter_issue = bundle_ok && |(elig & is_iter);
    end

    vig_iter_fsm #(
        .RECOVERY (ITER_RECOVERY)
    ) u_iter (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (iter_issue),
        .busy  (iter_busy)
    );

    vig_wb_window #(
        .DEPTH     (MAX_LAT),
        .NUM_SLOTS (NUM_SLOTS),
        .WB_PORTS  (WB_PORTS),
        .LAT_W     (LAT_W),
        .CNT_W     (CNT_W)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (bundle_ok),
        .add_en   (elig),
        .add_lat  (lat_flat),
        .occ_flat (occ_flat)
    );

endmodule

// File: tb/tb_vliw_issue_guard.sv
module tb_vliw_issue_guard;

    localparam int NS   = 5;
    localparam int PORTS = 5;
    localparam int ILAT = 17;
    localparam int IREC = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] slot_valid = '0;
    logic [NS*4-1:0] slot_unit = '0;
    logic          bundle_ok;
    logic [NS*2-1:0] slot_err;

    int checks = 0;
    int fails  = 0;

    int m_resv [ILAT];
    int m_busy;
    int e_code [NS];
    bit e_ok;

    always #5 clk = ~clk;

    vliw_issue_guard #(
        .NUM_SLOTS (NS), .WB_PORTS (PORTS), .ITER_LAT (ILAT), .ITER_RECOVERY (IREC)
    ) dut (
        .clk (clk), .rst_n (rst_n), .slot_valid (slot_valid), .slot_unit (slot_unit),
        .bundle_ok (bundle_ok), .slot_err (slot_err)
    );

    // {exp_ok, valid[4:0], unit s4,s3,s2,s1,s0}
    localparam logic [25:0] VEC [13] = '{
        {1'b1, 5'b11111, 4'd1, 4'd1, 4'd1, 4'd1, 4'd1},
        {1'b1, 5'b11111, 4'd4, 4'd8, 4'd9, 4'd3, 4'd8},
        {1'b0, 5'b00001, 4'd0, 4'd0, 4'd0, 4'd0, 4'd2},
        {1'b0, 5'b00001, 4'd0, 4'd0, 4'd0, 4'd0, 4'd1},
        {1'b1, 5'b00001, 4'd0, 4'd0, 4'd0, 4'd0, 4'd1},
        {1'b1, 5'b00010, 4'd0, 4'd0, 4'd0, 4'd11, 4'd0},
        {1'b0, 5'b00010, 4'd0, 4'd0, 4'd0, 4'd11, 4'd0},
        {1'b1, 5'b00111, 4'd0, 4'd0, 4'd10, 4'd6, 4'd6},
        {1'b0, 5'b00001, 4'd0, 4'd0, 4'd0, 4'd0, 4'd15},
        {1'b0, 5'b00100, 4'd0, 4'd0, 4'd8, 4'd0, 4'd0},
        {1'b1, 5'b00000, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0},
        {1'b1, 5'b11101, 4'd5, 4'd7, 4'd2, 4'd0, 4'd0},
        {1'b0, 5'b00010, 4'd0, 4'd0, 4'd0, 4'd11, 4'd0}
    };

    function automatic bit b_attached(int s, int c);
        logic [4:0] m;
        case (c)
            0, 1: m = 5'b11111;
            2:  m = 5'b10101;
            3:  m = 5'b00110;
            4:  m = 5'b11000;
            5:  m = 5'b10000;
            6:  m = 5'b00011;
            7:  m = 5'b01110;
            8:  m = 5'b01001;
            9:  m = 5'b00110;
            10: m = 5'b00100;
            11: m = 5'b00010;
            default: m = 5'b00000;
        endcase
        return m[s];
    endfunction

    function automatic int b_lat(int c);
        case (c)
            0, 1, 6, 10: return 1;
            2: return 2;
            3, 4, 5, 7, 8, 9: return 3;
            11: return ILAT;
            default: return 1;
        endcase
    endfunction

    task automatic check(bit good, string tag, string what, int act, int exp);
        checks++;
        if (!good) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int d = 0; d < ILAT; d++) m_resv[d] = 0;
        m_busy = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; slot_valid = '0; slot_unit = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Present one bundle, compare against the reference model, then advance it.
    task automatic step(logic [NS-1:0] v, logic [NS*4-1:0] ty, string tag);
        bit claim;
        bit elig [NS];
        int nw [ILAT];
        bit it_issue;
        @(negedge clk);
        slot_valid = v; slot_unit = ty;
        #1;
        claim = (m_busy > 0);
        for (int s = 0; s < NS; s++) begin
            int c = int'(ty[s*4 +: 4]);
            e_code[s] = 0; elig[s] = 1'b0;
            if (v[s]) begin
                if (!b_attached(s, c)) e_code[s] = 1;
                else if (c == 11 && claim) e_code[s] = 2;
                else begin elig[s] = 1'b1; if (c == 11) claim = 1'b1; end
            end
        end
        for (int s = 0; s < NS; s++) begin
            if (elig[s]) begin
                int l = b_lat(int'(ty[s*4 +: 4]));
                int n = m_resv[l-1];
                for (int k = 0; k <= s; k++)
                    if (elig[k] && b_lat(int'(ty[k*4 +: 4])) == l) n++;
                if (n > PORTS) e_code[s] = 3;
            end
        end
        e_ok = 1'b1;
        for (int s = 0; s < NS; s++) if (e_code[s] != 0) e_ok = 1'b0;
        check(bundle_ok == e_ok, tag, "bundle_ok", int'(bundle_ok), int'(e_ok));
        for (int s = 0; s < NS; s++)
            check(int'(slot_err[s*2 +: 2]) == e_code[s], tag, $sformatf("slot%0d code", s),
                  int'(slot_err[s*2 +: 2]), e_code[s]);
        it_issue = 1'b0;
        for (int d = 0; d < ILAT; d++) nw[d] = (d + 1 < ILAT) ? m_resv[d+1] : 0;
        if (e_ok) begin
            for (int s = 0; s < NS; s++) begin
                if (elig[s]) begin
                    int l = b_lat(int'(ty[s*4 +: 4]));
                    if (l >= 2) nw[l-2]++;
                    if (ty[s*4 +: 4] == 4'd11) it_issue = 1'b1;
                end
            end
        end
        for (int d = 0; d < ILAT; d++) m_resv[d] = nw[d];
        if (it_issue) m_busy = IREC - 1;
        else if (m_busy > 0) m_busy--;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();

        // R8: empty state after reset, a full bundle of 1-cycle ops fits
        step(5'b00000, '0, "R8");
        check(bundle_ok == 1'b1 && slot_err == '0, "R8", "empty after reset", int'(bundle_ok), 1);
        step(5'b11111, {4'd1, 4'd1, 4'd0, 4'd1, 4'd0}, "R8");
        step(5'b00010, {4'd0, 4'd0, 4'd0, 4'd11, 4'd0}, "R8");
        check(bundle_ok == 1'b1, "R8", "iterative idle after reset", int'(bundle_ok), 1);

        // Table walk: bundle accept decisions (R6)
        do_reset();
        for (int n = 0; n < 13; n++) begin
            step(VEC[n][24:20], VEC[n][19:0], "R6");
            check(bundle_ok == VEC[n][25], "R6", $sformatf("table %0d accept", n),
                  int'(bundle_ok), int'(VEC[n][25]));
        end

        // R1: unit not attached to slot
        do_reset();
        step(5'b00101, {4'd0, 4'd0, 4'd8, 4'd0, 4'd1}, "R1");
        check(slot_err[5:4] == 2'd1 && slot_err[1:0] == 2'd0, "R1", "fp add on slot 2", int'(slot_err[5:4]), 1);
        step(5'b10000, {4'd13, 4'd0, 4'd0, 4'd0, 4'd0}, "R1");
        check(slot_err[9:8] == 2'd1, "R1", "undefined code", int'(slot_err[9:8]), 1);

        // R4: recovery window of the iterative unit
        do_reset();
        step(5'b00010, {4'd0, 4'd0, 4'd0, 4'd11, 4'd0}, "R4");
        for (int k = 1; k <= IREC; k++) begin
            step(5'b00010, {4'd0, 4'd0, 4'd0, 4'd11, 4'd0}, "R4");
            check(bundle_ok == (k == IREC), "R4", $sformatf("reissue at +%0d", k),
                  int'(bundle_ok), int'(k == IREC));
        end

        // R3: precedence, attachment before recovery
        do_reset();
        step(5'b00010, {4'd0, 4'd0, 4'd0, 4'd11, 4'd0}, "R3");
        step(5'b11111, {4'd1, 4'd1, 4'd1, 4'd11, 4'd11}, "R3");
        check(slot_err[1:0] == 2'd1 && slot_err[3:2] == 2'd2, "R3", "slot0/slot1 codes",
              int'(slot_err[3:0]), 9);

        // R5 and R2: long-latency booking collides with later short ops
        do_reset();
        step(5'b00010, {4'd0, 4'd0, 4'd0, 4'd11, 4'd0}, "R2");
        for (int k = 1; k <= 13; k++) step(5'b00000, '0, "R2");
        step(5'b01111, {4'd0, 4'd8, 4'd9, 4'd3, 4'd8}, "R5");
        check(bundle_ok == 1'b1, "R5", "fills to limit", int'(bundle_ok), 1);
        step(5'b00001, {4'd0, 4'd0, 4'd0, 4'd0, 4'd2}, "R5");
        check(slot_err[1:0] == 2'd3, "R5", "2-cycle op overflows", int'(slot_err[1:0]), 3);
        step(5'b00001, {4'd0, 4'd0, 4'd0, 4'd0, 4'd2}, "R2");
        check(bundle_ok == 1'b1, "R2", "next cycle free", int'(bundle_ok), 1);

        // R7: rejected bundle books nothing and does not start recovery
        do_reset();
        step(5'b01111, {4'd0, 4'd8, 4'd9, 4'd3, 4'd8}, "R7");
        step(5'b10001, {4'd15, 4'd0, 4'd0, 4'd0, 4'd2}, "R7");
        check(bundle_ok == 1'b0, "R7", "poisoned bundle rejected", int'(bundle_ok), 0);
        step(5'b00011, {4'd0, 4'd0, 4'd0, 4'd1, 4'd1}, "R7");
        check(slot_err[1:0] == 2'd0 && slot_err[3:2] == 2'd3, "R7", "probe codes",
              int'(slot_err[3:0]), 12);
        do_reset();
        step(5'b00011, {4'd0, 4'd0, 4'd0, 4'd11, 4'd14}, "R7");
        step(5'b00010, {4'd0, 4'd0, 4'd0, 4'd11, 4'd0}, "R7");
        check(bundle_ok == 1'b1, "R7", "iterative free after reject", int'(bundle_ok), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule